// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a clocked host read and write an external asynchronous static RAM of about one million 4-bit words. The RAM has active-low chip enable, output enable and write enable strobes and a shared data bus. The host side uses a simple handshake. A request is accepted only while the sequencer is idle. At that moment it takes the 20-bit address, the 4-bit write data and a read/write flag. A one-cycle ready pulse marks the end of each access, and for a read it comes with the returned data.

Every phase of an access lasts a whole number of clock cycles. Each length comes from a nanosecond limit in the RAM's timing: the ceiling of the limit divided by the clock period, with a minimum of one. A write is framed by write enable falling and rising while chip enable is low. Output enable stays high for the whole write, so the RAM never drives the bus during it. After every read, a guard interval of cycles with all strobes off lets the RAM release the bus before the controller may drive it again.

The data bus appears as three separate signals: a driven value, a drive enable and a sampled input. The pad-level tri-state buffer sits outside the block. With the default 8 ns clock, the read access phase is 3 cycles, the address setup is 1 cycle, the write pulse is 2 cycles and the bus-release guard is 2 cycles.

Top module: `sram_async_ctrl`

## Requirements
- R1: While rst_ni is low, ram_ce_no, ram_oe_no and ram_we_no are high, ram_dq_oe_o is low and rdy_o is low.
- R2: In idle with no request, all three strobes are high, the bus is released (ram_dq_oe_o low) and rdy_o is low.
- R3: A request with we_i=0 accepted in idle gives RD_CYC cycles with ram_ce_no=0, ram_oe_no=0 and ram_we_no=1. It is followed by one cycle with ram_ce_no and ram_oe_no high and rdy_o=1, in which rdata_o equals the RAM data sampled at the end of the last access cycle.
- R4: A request with we_i=1 gives AS_CYC cycles with ram_ce_no=0, ram_we_no=1, ram_oe_no=1 and the bus released. Next come WP_CYC cycles with ram_we_no=0, ram_dq_oe_o=1 and ram_dq_o equal to the accepted write data. Last comes one hold cycle with ram_we_no=1, ram_ce_no=0 and the data still driven.
- R5: ram_oe_no is high in every cycle where ram_we_no is low or ram_dq_oe_o is high.
- R6: After the ready cycle of a read, TA_CYC cycles follow with all strobes high and the bus released before a new request can be accepted. The bus is never driven sooner than TA_CYC cycles after ram_oe_no rises.
- R7: rdy_o is high for exactly one cycle per accepted access. For a write this is the hold cycle.
- R8: req_i, we_i, addr_i and wdata_i have no effect outside idle. Address and write data are those present at acceptance.
- R9: ram_addr_o does not change while ram_ce_no stays low.
- R10: Phase lengths are ceil(limit_ns / CLK_PERIOD_NS) with a minimum of 1. The write pulse covers both the pulse-width and the data-setup limits. At 8 ns the lengths are RD_CYC=3, AS_CYC=1, WP_CYC=2 and TA_CYC=2. If the write total falls short of the minimum cycle time, extra idle tail cycles are added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled only in idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 20 | Word address |
| wdata_i | input | 4 | Write data |
| rdy_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 4 | Read data, valid with rdy_o after a read |
| ram_addr_o | output | 20 | Address to the RAM |
| ram_ce_no | output | 1 | Chip enable, active low |
| ram_oe_no | output | 1 | Output enable, active low |
| ram_we_no | output | 1 | Write enable, active low |
| ram_dq_o | output | 4 | Value driven onto the RAM data bus |
| ram_dq_oe_o | output | 1 | Bus drive enable for the pad buffer |
| ram_dq_i | input | 4 | Value sampled from the RAM data bus |

## Verification
A corrupted state register or phase counter shows up at the strobe pins in the very next cycle. A phase that is one cycle short or long shifts the rise of ram_oe_no or ram_we_no. A wrong next state yields a strobe combination, such as output enable low together with write enable low, that never occurs in a correct sequence. The bench compares every strobe, the drive enable and the ready pulse on every clock against a per-cycle expected stream. A stale capture register or address register therefore shows up in the ready cycle of that access or on the next read of the same word.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_DONE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOV,
    ST_TURN
  } ctrl_state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_drv;
    logic rdy;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_drv: 1'b0, rdy: 1'b0};

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic strobe_t decode_strobe(ctrl_state_e s);
    strobe_t r;
    r = STROBE_IDLE;
    case (s)
      ST_RD_ACC: begin
        r.ce_n = 1'b0;
        r.oe_n = 1'b0;
      end
      ST_RD_DONE:  r.rdy = 1'b1;
      ST_WR_SETUP: r.ce_n = 1'b0;
      ST_WR_PULSE: begin
        r.ce_n   = 1'b0;
        r.we_n   = 1'b0;
        r.dq_drv = 1'b1;
      end
      ST_WR_RECOV: begin
        r.ce_n   = 1'b0;
        r.dq_drv = 1'b1;
        r.rdy    = 1'b1;
      end
      default: r = STROBE_IDLE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);

  // R10: a loaded length is what the phase runs for
  a_r10_timer_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
  import sram_ctrl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  ctrl_state_e state_d_i,
  output strobe_t     strobe_o
);

  strobe_t strobe_q;

  // registered so the RAM pins never see decode glitches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= STROBE_IDLE;
    else         strobe_q <= decode_strobe(state_d_i);
  end

  assign strobe_o = strobe_q;

  a_r5_oe_off_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_q.we_n || strobe_q.dq_drv) |-> strobe_q.oe_n);

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_cap_i,
  input  logic [DATA_W-1:0] ram_dq_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (rd_cap_i) rdata_q <= ram_dq_i;
  end

  assign ram_addr_o = addr_q;
  assign ram_dq_o   = wdata_q;
  assign rdata_o    = rdata_q;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 20,
  parameter int unsigned DATA_W        = 4,
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned T_ACCESS_NS   = 20,
  parameter int unsigned T_WPULSE_NS   = 15,
  parameter int unsigned T_DSETUP_NS   = 10,
  parameter int unsigned T_ASETUP_NS   = 0,
  parameter int unsigned T_RELEASE_NS  = 9,
  parameter int unsigned T_CYCLE_NS    = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_ce_no,
  output logic              ram_oe_no,
  output logic              ram_we_no,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe_o,
  input  logic [DATA_W-1:0] ram_dq_i
);

  localparam int unsigned RD_CYC  = ns_to_cyc(T_ACCESS_NS, CLK_PERIOD_NS);
  localparam int unsigned AS_CYC  = ns_to_cyc(T_ASETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned WP_CYC  = max2(ns_to_cyc(T_WPULSE_NS, CLK_PERIOD_NS),
                                         ns_to_cyc(T_DSETUP_NS, CLK_PERIOD_NS));
  localparam int unsigned TA_CYC  = ns_to_cyc(T_RELEASE_NS, CLK_PERIOD_NS);
  localparam int unsigned CY_CYC  = ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int unsigned WR_TAIL = (CY_CYC > AS_CYC + WP_CYC + 1) ? CY_CYC - AS_CYC - WP_CYC - 1 : 0;
  localparam int unsigned TAIL_LD = (WR_TAIL > 0) ? WR_TAIL - 1 : 0;
  localparam int unsigned MAX_LEN = max2(max2(RD_CYC, AS_CYC), max2(max2(WP_CYC, TA_CYC), WR_TAIL));
  localparam int unsigned CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam int unsigned MON_W   = CNT_W + 2;

  ctrl_state_e      state_q, state_d;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             last;
  logic             accept;
  logic             rd_cap;
  strobe_t          stb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (req_i) state_d = we_i ? ST_WR_SETUP : ST_RD_ACC;
      ST_RD_ACC:   if (last) state_d = ST_RD_DONE;
      ST_RD_DONE:  state_d = ST_TURN;
      ST_TURN:     if (last) state_d = ST_IDLE;
      ST_WR_SETUP: if (last) state_d = ST_WR_PULSE;
      ST_WR_PULSE: if (last) state_d = ST_WR_RECOV;
      ST_WR_RECOV: state_d = (WR_TAIL > 0) ? ST_TURN : ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state_d)
      ST_RD_ACC:   load_val = CNT_W'(RD_CYC - 1);
      ST_WR_SETUP: load_val = CNT_W'(AS_CYC - 1);
      ST_WR_PULSE: load_val = CNT_W'(WP_CYC - 1);
      ST_TURN:     load_val = (state_q == ST_WR_RECOV) ? CNT_W'(TAIL_LD) : CNT_W'(TA_CYC - 1);
      default:     load_val = '0;
    endcase
  end

  assign load   = (state_d != state_q);
  assign accept = (state_q == ST_IDLE) && req_i;
  assign rd_cap = (state_q == ST_RD_ACC) && last;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .last_o     (last)
  );

  sram_strobe_gen u_strobe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_d_i (state_d),
    .strobe_o  (stb)
  );

  sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rd_cap_i   (rd_cap),
    .ram_dq_i   (ram_dq_i),
    .ram_addr_o (ram_addr_o),
    .ram_dq_o   (ram_dq_o),
    .rdata_o    (rdata_o)
  );

  assign ram_ce_no   = stb.ce_n;
  assign ram_oe_no   = stb.oe_n;
  assign ram_we_no   = stb.we_n;
  assign ram_dq_oe_o = stb.dq_drv;
  assign rdy_o       = stb.rdy;

  // monitors for pulse width and bus-release spacing
  logic [MON_W-1:0] we_low_cnt, oe_high_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_low_cnt  <= '0;
      oe_high_cnt <= '1;
    end else begin
      if (ram_we_no)               we_low_cnt <= '0;
      else if (we_low_cnt != '1)   we_low_cnt <= we_low_cnt + 1'b1;
      if (!ram_oe_no)              oe_high_cnt <= '0;
      else if (oe_high_cnt != '1)  oe_high_cnt <= oe_high_cnt + 1'b1;
    end
  end

  a_r4_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_we_no) |-> (we_low_cnt >= MON_W'(WP_CYC)));

  a_r4_write_in_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_no |-> (!ram_ce_no && ram_dq_oe_o));

  a_r4_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_dq_oe_o && $past(ram_dq_oe_o)) |-> $stable(ram_dq_o));

  a_r6_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_dq_oe_o) |-> (oe_high_cnt >= MON_W'(TA_CYC)));

  a_r7_rdy_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |=> !rdy_o);

  a_r9_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_ce_no && $past(!ram_ce_no)) |-> $stable(ram_addr_o));

endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;

  localparam int CLK_NS = 8;

  function automatic int cyc(int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  // R10: expected phase lengths from the timing limits
  localparam int RD = cyc(20);
  localparam int AS = cyc(0);
  localparam int WP = (cyc(15) > cyc(10)) ? cyc(15) : cyc(10);
  localparam int TA = cyc(9);
  localparam int CY = cyc(20);
  localparam int TAIL = (CY > AS + WP + 1) ? CY - AS - WP - 1 : 0;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [19:0] addr_i = '0;
  logic [3:0]  wdata_i = '0;
  logic        rdy_o;
  logic [3:0]  rdata_o;
  logic [19:0] ram_addr_o;
  logic        ram_ce_no, ram_oe_no, ram_we_no, ram_dq_oe_o;
  logic [3:0]  ram_dq_o;
  logic [3:0]  ram_dq_i = 'x;

  always #(CLK_NS/2) clk = ~clk;

  sram_async_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdy_o(rdy_o), .rdata_o(rdata_o),
    .ram_addr_o(ram_addr_o), .ram_ce_no(ram_ce_no), .ram_oe_no(ram_oe_no),
    .ram_we_no(ram_we_no), .ram_dq_o(ram_dq_o), .ram_dq_oe_o(ram_dq_oe_o),
    .ram_dq_i(ram_dq_i)
  );

  // RAM model: small array, data valid only after the access time
  logic [3:0] ram_mem [256];
  logic [3:0] ref_mem [256];
  int rd_age = 0;

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram_mem[i] = 4'((i * 7 + 3) & 15);
      ref_mem[i] = 4'((i * 7 + 3) & 15);
    end
  end

  always @(negedge clk) begin
    int age;
    if (!ram_ce_no && !ram_oe_no && ram_we_no) age = rd_age + 1;
    else age = 0;
    rd_age <= age;
    if (age > 0 && ((age - 1) * CLK_NS + CLK_NS / 2) >= 20) ram_dq_i <= ram_mem[ram_addr_o[7:0]];
    else ram_dq_i <= 'x;
    if (!ram_ce_no && !ram_we_no && ram_dq_oe_o) ram_mem[ram_addr_o[7:0]] <= ram_dq_o;
  end

  typedef struct {
    logic [4:0]  stb;   // {ce_n, oe_n, we_n, drv, rdy}
    logic [19:0] addr;
    logic [3:0]  dq;
    logic [3:0]  rd;
    logic        rd_chk;
  } exp_t;

  exp_t  eq[$];
  string tq[$];
  int n_chk = 0;
  int n_fail = 0;
  bit in_reset = 1'b1;
  bit done = 1'b0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic push(logic [4:0] stb, logic [19:0] a, logic [3:0] d, logic [3:0] r, logic rc, string tag);
    exp_t e;
    e.stb = stb; e.addr = a; e.dq = d; e.rd = r; e.rd_chk = rc;
    eq.push_back(e);
    tq.push_back(tag);
  endtask

  task automatic tick();
    exp_t e;
    string t;
    logic [4:0] act;
    @(negedge clk);
    if (eq.size() > 0) begin
      e = eq.pop_front();
      t = tq.pop_front();
    end else begin
      e.stb = 5'b11100; e.addr = '0; e.dq = '0; e.rd = '0; e.rd_chk = 1'b0;
      t = in_reset ? "R1 reset" : "R2 idle";
    end
    act = {ram_ce_no, ram_oe_no, ram_we_no, ram_dq_oe_o, rdy_o};
    check(act === e.stb, {t, " strobes"}, 32'(act), 32'(e.stb));
    if (e.stb[4] == 1'b0)
      check(ram_addr_o === e.addr, "R8/R9 address", 32'(ram_addr_o), 32'(e.addr));
    if (e.stb[1])
      check(ram_dq_o === e.dq, "R4/R8 write data", 32'(ram_dq_o), 32'(e.dq));
    if (e.rd_chk)
      check(rdata_o === e.rd, "R3 read data", 32'(rdata_o), 32'(e.rd));
    if (ram_we_no === 1'b0 || ram_dq_oe_o === 1'b1)
      check(ram_oe_no === 1'b1, "R5 oe off", 32'(ram_oe_no), 32'h1);
  endtask

  task automatic run_access(logic w, logic [19:0] a, logic [3:0] d);
    tick();  // one idle cycle so the request lands in idle
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    if (!w) begin
      for (int i = 0; i < RD; i++) push(5'b00100, a, '0, '0, 1'b0, "R3 R10 read access");
      push(5'b11101, '0, '0, ref_mem[a[7:0]], 1'b1, "R7 read ready");
      for (int i = 0; i < TA; i++) push(5'b11100, '0, '0, '0, 1'b0, "R6 turnaround");
    end else begin
      for (int i = 0; i < AS; i++) push(5'b01100, a, '0, '0, 1'b0, "R4 R10 addr setup");
      for (int i = 0; i < WP; i++) push(5'b01010, a, d, '0, 1'b0, "R4 R10 write pulse");
      push(5'b01111, a, d, '0, 1'b0, "R4 R7 write hold");
      for (int i = 0; i < TAIL; i++) push(5'b11100, '0, '0, '0, 1'b0, "R10 write tail");
      ref_mem[a[7:0]] = d;
    end
    while (eq.size() > 0) begin
      tick();
      if (rdy_o === 1'b1) req_i = 1'b0;
      // R8: scramble host inputs while busy
      addr_i  = 20'($urandom);
      wdata_i = 4'($urandom);
      we_i    = 1'($urandom);
    end
  endtask

  initial begin
    repeat (3) tick();            // R1
    rst_ni = 1'b1;
    in_reset = 1'b0;
    repeat (3) tick();            // R2
    run_access(1'b1, 20'h00005, 4'hA);
    run_access(1'b0, 20'h00005, 4'h0);
    run_access(1'b0, 20'h12340, 4'h0);   // untouched word
    run_access(1'b1, 20'hFFFFF, 4'h3);
    run_access(1'b1, 20'h000FE, 4'hC);   // write after write
    run_access(1'b0, 20'hFFFFF, 4'h0);
    run_access(1'b1, 20'h00005, 4'h6);   // write right after read
    run_access(1'b0, 20'h000FE, 4'h0);
    run_access(1'b0, 20'h00005, 4'h0);   // read after read
    repeat (4) tick();
    run_access(1'b1, 20'h80000, 4'hF);
    run_access(1'b0, 20'h80000, 4'h0);
    run_access(1'b0, 20'h00000, 4'h0);
    repeat (3) tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule